// File: doc/BRIEF.md
# SMBus Slave with Alert Response

This block is the serial management port of a multi-port power controller. It watches the SCL and SDA lines with the system clock and cleans each line with a synchronizer and a short majority-free run filter. It then decodes START, STOP and data bits and serves byte transfers against a small internal register file. The data line is split into an input pin and a separate pull-low output pin, so an isolation barrier such as an optocoupler can be placed in each direction. Tying the two pins together gives an ordinary bidirectional SDA.

The host uses three transfer shapes. Write Byte sends a command byte and then a data byte. Read Byte sends a command byte, a repeated START and a read. Receive Byte is a bare read. The slave answers to an address made from a fixed upper part and four strap pins. It also answers to a shared broadcast address, but only for writes. While it is holding its active-low interrupt output asserted, it also answers to the alert response address. In that case it reports its own address.

The interrupt output only follows its request input while the bus is idle. Once a START has been seen, the output is frozen until a STOP.

Top module: `smb_alert_slave`

## Requirements
- R1: The slave address is 7 bits: binary 010 in the top three bits, followed by strapAddr[3:0] with bit 3 most significant. After each accepted byte the slave acknowledges by pulling SDA low for the ninth SCL pulse. A byte addressed to any unmatched address is not acknowledged.
- R2: In Write Byte, the command byte loads the register pointer from its low log2(NUM_REGS) bits (2 bits at the default of 4 registers). The following data byte is stored into the register at that pointer. Every byte of the transfer is acknowledged.
- R3: In Read Byte, a write of the command byte, a repeated START and a read with R/W bit 1 return the selected register MSB first. The slave changes its SDA drive only while SCL is low.
- R4: In Receive Byte, a read with no preceding command returns the register at the pointer left by the last command byte.
- R5: Address 0110000 with R/W 0 is acknowledged, and its command and data bytes write the register file exactly as the slave address does. Address 0110000 with R/W 1 is not acknowledged.
- R6: Address 0001100 with R/W 1 is acknowledged only while irqN is low. In that case the returned byte is the slave's own 7-bit address in bits 7..1, with bit 0 equal to 0. While irqN is high, that address is not acknowledged.
- R7: While no transfer is open (after reset or after a STOP), irqN follows the inverse of intReq within a few clocks. Between a START and the next STOP, irqN holds its value whatever intReq does.
- R8: A pulse shorter than three system clocks on SCL or on SDA is ignored. It creates no bit, no START and no STOP.
- R9: During a read, a master acknowledge (SDA low on the ninth pulse) makes the slave send the same register again. A master not-acknowledge makes the slave release SDA until the next START.
- R10: After reset, SDA is released, irqN is high while intReq is low, and every register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line from the bus |
| sdaIn | input | 1 | Serial data line as seen at the input pin |
| strapAddr | input | 4 | Strap pins that form the low four address bits |
| intReq | input | 1 | Active-high interrupt request from the controller core |
| sdaPullLow | output | 1 | 1 pulls the data line low; 0 releases it (never drives high) |
| irqN | output | 1 | Active-low interrupt, updated only between transfers |

## Verification
The bench checks the alert response address in both interrupt states. A design that ignored the interrupt gate would acknowledge it while irqN was high, and one that returned a register instead of its address would fail the data compare. It raises intReq in the middle of an open transfer: a design without the gate would drop irqN before the STOP. It sends a broadcast read, which a decoder that ignores the R/W bit would acknowledge. It injects two-clock spikes on SCL during a write and on SDA while the bus is idle; a missing filter would count an extra bit and store a shifted value. Finally, it reads with a master acknowledge and then a not-acknowledge, which catches a slave that advances the pointer or keeps driving SDA.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;

  localparam int BYTE_W = 8;
  localparam int STRAP_W = 4;

  // fixed upper part of the slave address, then the straps
  localparam logic [2:0] PRIMARY_HI = 3'b010;
  localparam logic [6:0] BCAST_ADDR = 7'b0110000;
  localparam logic [6:0] ALERT_ADDR = 7'b0001100;

  // control -> datapath strobes, one cycle each
  typedef struct packed {
    logic clrBits;
    logic takeBit;
    logic setPtr;
    logic wrReg;
    logic ackOn;
    logic freeSda;
    logic loadReg;
    logic loadAlert;
    logic shiftTx;
  } smbStrobe_t;

  // datapath -> control events and decodes
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic sclFall;
    logic sdaNow;
    logic byteDone;
    logic hitPrimary;
    logic hitBcast;
    logic hitAlert;
    logic rwBit;
  } smbStatus_t;

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawIn,
  output logic filtOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0] histQ;
  logic syncLast;

  assign syncLast = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '1;
      histQ <= '1;
      filtOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      histQ <= {histQ[FILT_LEN-2:0], syncLast};
      // output moves only when every stored sample agrees
      if (&histQ) filtOut <= 1'b1;
      else if (~|histQ) filtOut <= 1'b0;
    end
  end

  if (SYNC_STAGES == 2 && FILT_LEN == 3) begin : g_chk
    // R8
    rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(filtOut) |-> ($past(syncLast, 2) && $past(syncLast, 3) && $past(syncLast, 4)));
    // R8
    fall_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(filtOut) |-> (!$past(syncLast, 2) && !$past(syncLast, 3) && !$past(syncLast, 4)));
  end

endmodule

// File: rtl/smb_slave_datapath.sv
module smb_slave_datapath
  import smb_slave_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  smbStrobe_t stb,
  output smbStatus_t stat,
  output logic sdaPullLow
);

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic [1:0] rawLines;
  logic [1:0] fLines;
  logic fScl, fSda;
  logic sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxSh;
  logic [BYTE_W-1:0] txSh;
  logic [BYTE_W-1:0] alertByte;
  logic [PTR_W-1:0] ptr;
  logic [BYTE_W-1:0] regs [NUM_REGS];
  logic ackQ, txOn;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    smb_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN(FILT_LEN)
    ) u_filt (
      .clk(clk),
      .rst_n(rst_n),
      .rawIn(rawLines[g]),
      .filtOut(fLines[g])
    );
  end

  assign fScl = fLines[1];
  assign fSda = fLines[0];
  assign alertByte = {PRIMARY_HI, strapAddr, 1'b0};

  always_comb begin
    stat.sclRise = fScl & ~sclQ;
    stat.sclFall = ~fScl & sclQ;
    stat.startDet = sclQ & fScl & sdaQ & ~fSda;
    stat.stopDet = sclQ & fScl & ~sdaQ & fSda;
    stat.sdaNow = fSda;
    stat.byteDone = (bitCnt == FULL_CNT);
    stat.hitPrimary = (rxSh[BYTE_W-1:1] == {PRIMARY_HI, strapAddr});
    stat.hitBcast = (rxSh[BYTE_W-1:1] == BCAST_ADDR);
    stat.hitAlert = (rxSh[BYTE_W-1:1] == ALERT_ADDR);
    stat.rwBit = rxSh[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      bitCnt <= '0;
      rxSh <= '0;
      txSh <= '0;
      ptr <= '0;
      ackQ <= 1'b0;
      txOn <= 1'b0;
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
    end else begin
      sclQ <= fScl;
      sdaQ <= fSda;

      if (stb.clrBits) begin
        bitCnt <= '0;
      end else if (stb.takeBit) begin
        bitCnt <= bitCnt + 1'b1;
        rxSh <= {rxSh[BYTE_W-2:0], fSda};
      end

      if (stb.setPtr) ptr <= rxSh[PTR_W-1:0];

      if (stb.wrReg) begin
        for (int r = 0; r < NUM_REGS; r++)
          if (ptr == PTR_W'(r)) regs[r] <= rxSh;
      end

      if (stb.freeSda) begin
        ackQ <= 1'b0;
        txOn <= 1'b0;
      end else if (stb.ackOn) begin
        ackQ <= 1'b1;
        txOn <= 1'b0;
      end else if (stb.loadReg) begin
        ackQ <= 1'b0;
        txOn <= 1'b1;
        txSh <= regs[ptr];
      end else if (stb.loadAlert) begin
        ackQ <= 1'b0;
        txOn <= 1'b1;
        txSh <= alertByte;
      end else if (stb.shiftTx) begin
        txSh <= {txSh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // open-drain style: only ever pulls low
  assign sdaPullLow = ackQ | (txOn & ~txSh[BYTE_W-1]);

  // R3
  pull_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaPullLow) |-> !$past(fScl));
  // R2
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= FULL_CNT);

endmodule

// File: rtl/smb_slave_ctrl.sv
module smb_slave_ctrl
  import smb_slave_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  smbStatus_t stat,
  input  logic intReq,
  output smbStrobe_t stb,
  output logic irqN
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK, S_WAIT} state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DATA} phase_t;

  state_t stateQ, stateD;
  phase_t phaseQ, phaseD;
  logic busyQ, busyD;
  logic readQ, readD;
  logic alertQ, alertD;
  logic ackAddr;

  assign ackAddr = stat.hitPrimary
                 | (stat.hitBcast & ~stat.rwBit)
                 | (stat.hitAlert & stat.rwBit & ~irqN);

  always_comb begin
    stb = '0;
    stateD = stateQ;
    phaseD = phaseQ;
    busyD = busyQ;
    readD = readQ;
    alertD = alertQ;
    if (stat.stopDet) begin
      stateD = S_IDLE;
      busyD = 1'b0;
      stb.freeSda = 1'b1;
    end else if (stat.startDet) begin
      stateD = S_RX;
      phaseD = PH_ADDR;
      busyD = 1'b1;
      stb.clrBits = 1'b1;
      stb.freeSda = 1'b1;
    end else begin
      case (stateQ)
        S_RX: begin
          if (stat.sclRise) begin
            stb.takeBit = 1'b1;
          end else if (stat.sclFall && stat.byteDone) begin
            case (phaseQ)
              PH_ADDR: begin
                if (ackAddr) begin
                  stb.ackOn = 1'b1;
                  stateD = S_ACK;
                  phaseD = PH_CMD;
                  readD = stat.rwBit;
                  alertD = stat.hitAlert;
                end else begin
                  stateD = S_WAIT;
                end
              end
              PH_CMD: begin
                stb.setPtr = 1'b1;
                stb.ackOn = 1'b1;
                stateD = S_ACK;
                phaseD = PH_DATA;
              end
              default: begin
                stb.wrReg = 1'b1;
                stb.ackOn = 1'b1;
                stateD = S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (stat.sclFall) begin
            stb.clrBits = 1'b1;
            if (readQ) begin
              stb.loadAlert = alertQ;
              stb.loadReg = ~alertQ;
              stateD = S_TX;
            end else begin
              stb.freeSda = 1'b1;
              stateD = S_RX;
            end
          end
        end
        S_TX: begin
          if (stat.sclRise) begin
            stb.takeBit = 1'b1;
          end else if (stat.sclFall) begin
            if (stat.byteDone) begin
              stb.freeSda = 1'b1;
              stateD = S_TXACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (stat.sclRise && stat.sdaNow) begin
            stateD = S_WAIT;
          end else if (stat.sclFall) begin
            stb.clrBits = 1'b1;
            stb.loadAlert = alertQ;
            stb.loadReg = ~alertQ;
            stateD = S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= S_IDLE;
      phaseQ <= PH_ADDR;
      busyQ <= 1'b0;
      readQ <= 1'b0;
      alertQ <= 1'b0;
      irqN <= 1'b1;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
      busyQ <= busyD;
      readQ <= readD;
      alertQ <= alertD;
      if (!busyQ) irqN <= ~intReq;
    end
  end

  // R7
  irq_frozen_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irqN) |-> !$past(busyQ));
  // R6
  alert_only_when_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == S_ACK && alertQ) |-> !irqN);

endmodule

// File: rtl/smb_alert_slave.sv
module smb_alert_slave
  import smb_slave_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic intReq,
  output logic sdaPullLow,
  output logic irqN
);

  smbStrobe_t stb;
  smbStatus_t stat;

  smb_slave_datapath #(
    .NUM_REGS(NUM_REGS),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN(FILT_LEN)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .strapAddr(strapAddr),
    .stb(stb),
    .stat(stat),
    .sdaPullLow(sdaPullLow)
  );

  smb_slave_ctrl u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .stat(stat),
    .intReq(intReq),
    .stb(stb),
    .irqN(irqN)
  );

endmodule

// File: tb/smb_alert_slave_tb.sv
module smb_alert_slave_tb;

  localparam int Q = 20;
  localparam int H = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic intReq = 1'b0;
  logic [3:0] strap = 4'b1010;
  logic sdaPullLow, irqN, sdaLine;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  smb_alert_slave u_dut (
    .clk(clk),
    .rst_n(rst_n),
    .sclIn(sclM),
    .sdaIn(sdaLine),
    .strapAddr(strap),
    .intReq(intReq),
    .sdaPullLow(sdaPullLow),
    .irqN(irqN)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] expQ[$];
  logic [7:0] obsQ[$];
  string tagQ[$];

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic startC;
    sdaM = 1'b1; wt(Q);
    sclM = 1'b1; wt(H);
    sdaM = 1'b0; wt(H);
    sclM = 1'b0;
  endtask

  task automatic stopC;
    wt(Q); sdaM = 1'b0; wt(Q);
    sclM = 1'b1; wt(H);
    sdaM = 1'b1; wt(H);
  endtask

  task automatic bitW(input logic b);
    wt(Q); sdaM = b; wt(Q);
    sclM = 1'b1; wt(H);
    sclM = 1'b0;
  endtask

  // bit with a two-clock SCL spike in the low phase
  task automatic bitWG(input logic b);
    wt(Q); sdaM = b; wt(5);
    sclM = 1'b1; wt(2); sclM = 1'b0;
    wt(Q - 7);
    sclM = 1'b1; wt(H);
    sclM = 1'b0;
  endtask

  task automatic bitR(output logic b);
    wt(Q); sdaM = 1'b1; wt(Q);
    sclM = 1'b1; wt(H / 2);
    b = sdaLine; wt(H / 2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input bit glitch, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      if (glitch) bitWG(v[i]);
      else bitW(v[i]);
    end
    bitR(b);
    acked = ~b;
  endtask

  task automatic recvByte(input logic [7:0] exp, input string req, input logic mAck);
    logic [7:0] v;
    logic b;
    expQ.push_back(exp);
    tagQ.push_back(req);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bitR(b);
      v = {v[6:0], b};
    end
    bitW(~mAck);
    obsQ.push_back(v);
  endtask

  task automatic writeReg(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] data,
                          input bit glitch, input string req);
    logic ak;
    startC;
    sendByte({a, 1'b0}, 1'b0, ak); chkEq(req, "write addr ack", int'(ak), 1);
    sendByte(cmd, glitch, ak);     chkEq(req, "cmd ack", int'(ak), 1);
    sendByte(data, glitch, ak);    chkEq(req, "data ack", int'(ak), 1);
    stopC;
  endtask

  task automatic readReg(input logic [7:0] cmd, input logic [7:0] exp, input string req);
    logic ak;
    startC;
    sendByte(8'h54, 1'b0, ak); chkEq(req, "read-cmd addr ack", int'(ak), 1);
    sendByte(cmd, 1'b0, ak);   chkEq(req, "read-cmd ack", int'(ak), 1);
    startC;
    sendByte(8'h55, 1'b0, ak); chkEq(req, "read addr ack", int'(ak), 1);
    recvByte(exp, req, 1'b0);
    stopC;
  endtask

  task automatic probeAddr(input logic [7:0] addrByte, input int expAck, input string req);
    logic ak;
    startC;
    sendByte(addrByte, 1'b0, ak);
    chkEq(req, "address ack", int'(ak), expAck);
    stopC;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (obsQ.size() > 0) begin
        logic [7:0] o;
        logic [7:0] e;
        string t;
        o = obsQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chkEq(t, "read data", int'(o), int'(e));
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ak;
    wt(6);
    rst_n = 1'b1;
    wt(3);
    // R10 reset state
    chkEq("R10", "sda released", int'(sdaPullLow), 0);
    chkEq("R10", "irq idle high", int'(irqN), 1);
    readReg(8'h03, 8'h00, "R10");

    // R1 R2 R3 write then read back
    writeReg(7'h2A, 8'h02, 8'hA5, 1'b0, "R2");
    readReg(8'h02, 8'hA5, "R3");
    writeReg(7'h2A, 8'h01, 8'h3C, 1'b0, "R2");
    readReg(8'h01, 8'h3C, "R3");

    // R4 receive byte at current pointer (1)
    startC;
    sendByte(8'h55, 1'b0, ak); chkEq("R4", "recv addr ack", int'(ak), 1);
    recvByte(8'h3C, "R4", 1'b0);
    stopC;

    // R1 unmatched address
    probeAddr(8'h56, 0, "R1");

    // R5 broadcast write and read
    writeReg(7'h30, 8'h00, 8'h77, 1'b0, "R5");
    readReg(8'h00, 8'h77, "R5");
    probeAddr(8'h61, 0, "R5");

    // R6 alert address without interrupt
    probeAddr(8'h19, 0, "R6");

    // R6 alert address with interrupt pending
    intReq = 1'b1; wt(5);
    chkEq("R7", "irq follows when idle", int'(irqN), 0);
    startC;
    sendByte(8'h19, 1'b0, ak); chkEq("R6", "alert ack", int'(ak), 1);
    recvByte(8'h54, "R6", 1'b0);
    stopC;
    intReq = 1'b0; wt(5);
    chkEq("R7", "irq clears when idle", int'(irqN), 1);

    // R7 request raised inside a transfer
    startC;
    sendByte(8'h54, 1'b0, ak);
    intReq = 1'b1; wt(60);
    chkEq("R7", "irq frozen mid transfer", int'(irqN), 1);
    sendByte(8'h00, 1'b0, ak);
    sendByte(8'h77, 1'b0, ak);
    chkEq("R7", "still frozen before stop", int'(irqN), 1);
    stopC;
    wt(5);
    chkEq("R7", "irq after stop", int'(irqN), 0);
    intReq = 1'b0; wt(5);
    chkEq("R7", "irq released idle", int'(irqN), 1);

    // R8 spikes on SDA while idle and on SCL during a write
    sdaM = 1'b0; wt(2); sdaM = 1'b1; wt(H);
    chkEq("R8", "no false start/stop", int'(sdaPullLow), 0);
    writeReg(7'h2A, 8'h03, 8'h96, 1'b1, "R8");
    readReg(8'h03, 8'h96, "R8");

    // R9 master ack repeats, nack releases
    startC;
    sendByte(8'h55, 1'b0, ak); chkEq("R9", "recv addr ack", int'(ak), 1);
    recvByte(8'h96, "R9", 1'b1);
    recvByte(8'h96, "R9", 1'b0);
    wt(Q);
    chkEq("R9", "sda released after nack", int'(sdaPullLow), 0);
    bitW(1'b1);
    chkEq("R9", "still released next pulse", int'(sdaPullLow), 0);
    stopC;

    wt(10);
    chkEq("R3", "scoreboard drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule